// File: doc/BRIEF.md
# Shift, Negate and Multiply ALU Slice

This block is the execution slice of an 8-bit accumulator CPU for the register-only opcodes. The slice takes an opcode, the current accumulator (A), index register (X), condition code register (CCR) and an optional immediate operand. From these it produces the next A, X and CCR. It covers these operations:

- logical shift left and right, on A or on X
- two's-complement negate, on A or on X
- nibble swap of A
- unsigned 8x8 multiply, with the product written to the X:A pair
- inclusive OR of A with an immediate
- no-operation

Each opcode has its own rule for each flag: cleared, recomputed from the result, or passed through. Each opcode also has a fixed latency in cycles.

A request is taken on a rising clock edge where `op_valid` is high and the slice is not busy. Every input is captured at that edge. The results are registered on the outputs after the opcode's cycle count, and `done` pulses for one cycle at that moment. The outputs then hold until the next completion. Requests that arrive while a multi-cycle operation is in flight are dropped. An opcode outside the set leaves every value unchanged and raises `illegal` together with `done`.

Top module: `alu_slice`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) a_out and x_out are 0x00, ccr_out is 0x60, and done, illegal and busy are 0. CCR layout: bit 7 V, bits 6 and 5 fixed 1, bit 4 H, bit 3 I, bit 2 N, bit 1 Z, bit 0 C.
- R2: Opcodes 0x48 (A) and 0x58 (X) shift the operand left by one with 0 entering bit 0. C takes the old bit 7, N takes result bit 7, Z is set for a zero result and V = N xor C. H and I pass through, the other register passes through, and the latency is 1 cycle.
- R3: Opcodes 0x44 (A) and 0x54 (X) shift the operand right by one with 0 entering bit 7. C takes the old bit 0, N is 0, V equals C and Z is set for a zero result. H and I pass through and the latency is 1 cycle.
- R4: Opcodes 0x40 (A) and 0x50 (X) replace the operand with 0x00 minus the operand. V is set only for operand 0x80, C is set when the result is non-zero, and N and Z follow the result. H and I pass through and the latency is 1 cycle.
- R5: Opcode 0x62 swaps the two nibbles of A. X and all flags pass through and the latency is 1 cycle.
- R6: Opcode 0x42 writes X*A (unsigned, 16 bits) with the high byte to x_out and the low byte to a_out. H and C are cleared, the other flags pass through, and the latency is 5 cycles.
- R7: Opcode 0xAA writes A | mem_in to A. V is cleared, N and Z follow the result, H, I and C pass through, X passes through, and the latency is 2 cycles.
- R8: Opcode 0x9D passes A, X and the CCR through unchanged with a latency of 1 cycle.
- R9: Any other opcode passes A, X and the CCR through unchanged, with a latency of 1 cycle, and raises illegal high in the same cycle as done.
- R10: ccr_out bits 6 and 5 are always 1, whatever ccr_in holds.
- R11: A request is accepted at a rising edge E where op_valid is 1 and busy is 0. The outputs are written at edge E+N-1, where N is the opcode's latency, and done is 1 for the cycle after that edge. busy is 1 from edge E until edge E+N-1 when N > 1. Single-cycle requests can be accepted on consecutive edges.
- R12: op_valid is ignored while busy is 1, including at the completion edge. Such a request has no effect on the results and produces no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Request strobe |
| opcode | input | 8 | Operation code |
| a_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current index register |
| ccr_in | input | 8 | Current condition code register |
| mem_in | input | 8 | Immediate operand for the OR opcode |
| a_out | output | 8 | Accumulator after the operation |
| x_out | output | 8 | Index register after the operation |
| ccr_out | output | 8 | Condition code register after the operation |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Undefined opcode completed (with done) |
| busy | output | 1 | Multi-cycle operation in flight |

## Verification
The completion of a multiply or OR can land in the same cycle as a fresh request. A stream of back-to-back single-cycle opcodes likewise puts an acceptance and a completion on every edge. The bench provokes the first case by holding op_valid high with a different opcode and altered operands through the whole busy window, including the completion edge. It then judges that the results and the done timing match the original request alone, and that no extra done appears. Uninterrupted runs of one-cycle opcodes must each yield their own result exactly one cycle after acceptance.

// File: rtl/alu_slice_pkg.sv
// Package: opcode values, operation kinds, decoded-op record and CCR bit
// positions shared by the ALU slice modules. Assumes an 8-bit CCR.
package alu_slice_pkg;
    localparam logic [7:0] OPC_LSLA = 8'h48;
    localparam logic [7:0] OPC_LSLX = 8'h58;
    localparam logic [7:0] OPC_LSRA = 8'h44;
    localparam logic [7:0] OPC_LSRX = 8'h54;
    localparam logic [7:0] OPC_NEGA = 8'h40;
    localparam logic [7:0] OPC_NEGX = 8'h50;
    localparam logic [7:0] OPC_NSA  = 8'h62;
    localparam logic [7:0] OPC_MUL  = 8'h42;
    localparam logic [7:0] OPC_ORAI = 8'hAA;
    localparam logic [7:0] OPC_NOP  = 8'h9D;

    localparam int CC_V = 7;
    localparam int CC_H = 4;
    localparam int CC_I = 3;
    localparam int CC_N = 2;
    localparam int CC_Z = 1;
    localparam int CC_C = 0;
    localparam logic [7:0] CCR_FIXED = 8'h60;

    typedef enum logic [2:0] {
        K_NOP, K_LSL, K_LSR, K_NEG, K_NSA, K_MUL, K_ORA, K_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     on_x;
    } op_dec_t;
endpackage

// File: rtl/alu_slice_decode.sv
// Decoder: maps an opcode to its operation kind, target register and fixed
// latency. Assumes opcodes outside the listed set are undefined.
module alu_slice_decode
    import alu_slice_pkg::*;
#(
    parameter int MUL_CYCLES = 5,
    parameter int ORA_CYCLES = 2,
    parameter int CNT_W      = 3
) (
    input  logic [7:0]       opcode,
    output op_dec_t          dec,
    output logic [CNT_W-1:0] cycles
);
    localparam logic [CNT_W-1:0] ONE_CYC = CNT_W'(1);

    // Opcode lookup.
    always_comb begin
        dec.on_x = 1'b0;
        cycles   = ONE_CYC;
        unique case (opcode)
            OPC_LSLA: dec.kind = K_LSL;
            OPC_LSLX: begin dec.kind = K_LSL; dec.on_x = 1'b1; end
            OPC_LSRA: dec.kind = K_LSR;
            OPC_LSRX: begin dec.kind = K_LSR; dec.on_x = 1'b1; end
            OPC_NEGA: dec.kind = K_NEG;
            OPC_NEGX: begin dec.kind = K_NEG; dec.on_x = 1'b1; end
            OPC_NSA:  dec.kind = K_NSA;
            OPC_MUL:  begin dec.kind = K_MUL; cycles = CNT_W'(MUL_CYCLES); end
            OPC_ORAI: begin dec.kind = K_ORA; cycles = CNT_W'(ORA_CYCLES); end
            OPC_NOP:  dec.kind = K_NOP;
            default:  dec.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/alu_slice_exec.sv
// Execution datapath: computes next A, X and CCR from a decoded operation.
// Purely combinational; assumes operands are stable while it is consulted.
module alu_slice_exec
    import alu_slice_pkg::*;
#(
    parameter int W = 8
) (
    input  op_dec_t        dec,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   x,
    input  logic [7:0]     ccr,
    input  logic [W-1:0]   m,
    output logic [W-1:0]   res_a,
    output logic [W-1:0]   res_x,
    output logic [7:0]     res_ccr
);
    localparam int HALF = W / 2;
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic [2*W-1:0] prod;
    logic [W-1:0]   opnd;
    logic [W-1:0]   r;
    logic           cout;
    logic [7:0]     cc;
    logic           wr_r;

    // Unsigned full-width product of the two registers.
    assign prod = {{W{1'b0}}, x} * {{W{1'b0}}, a};

    // Per-kind result and flag update.
    always_comb begin
        opnd = dec.on_x ? x : a;
        r    = opnd;
        cout = 1'b0;
        cc   = ccr;
        wr_r = 1'b0;
        case (dec.kind)
            K_LSL: begin
                {cout, r} = {opnd, 1'b0};
                cc[CC_N]  = r[W-1];
                cc[CC_Z]  = (r == '0);
                cc[CC_C]  = cout;
                cc[CC_V]  = r[W-1] ^ cout;
                wr_r      = 1'b1;
            end
            K_LSR: begin
                {r, cout} = {1'b0, opnd};
                cc[CC_N]  = 1'b0;
                cc[CC_Z]  = (r == '0);
                cc[CC_C]  = cout;
                cc[CC_V]  = cout;
                wr_r      = 1'b1;
            end
            K_NEG: begin
                r        = '0 - opnd;
                cc[CC_V] = (opnd == MIN_NEG);
                cc[CC_N] = r[W-1];
                cc[CC_Z] = (r == '0);
                cc[CC_C] = (r != '0);
                wr_r     = 1'b1;
            end
            K_NSA: begin
                r    = {opnd[HALF-1:0], opnd[W-1:HALF]};
                wr_r = 1'b1;
            end
            K_MUL: begin
                cc[CC_H] = 1'b0;
                cc[CC_C] = 1'b0;
            end
            K_ORA: begin
                r        = opnd | m;
                cc[CC_V] = 1'b0;
                cc[CC_N] = r[W-1];
                cc[CC_Z] = (r == '0);
                wr_r     = 1'b1;
            end
            default: ;
        endcase
    end

    // Route results to the destination registers.
    always_comb begin
        res_a = a;
        res_x = x;
        if (dec.kind == K_MUL) begin
            res_x = prod[2*W-1:W];
            res_a = prod[W-1:0];
        end else if (wr_r) begin
            if (dec.on_x) res_x = r;
            else          res_a = r;
        end
        res_ccr = cc | CCR_FIXED;
    end
endmodule

// File: rtl/alu_slice_seq.sv
// Sequencer: accepts a request when idle, counts the opcode latency and
// signals the completion edge. Assumes cycles is at least 1.
module alu_slice_seq #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [CNT_W-1:0] cycles,
    output logic             accept,
    output logic             commit,
    output logic             busy
);
    localparam logic [CNT_W-1:0] ONE_CYC = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO_CYC = CNT_W'(2);

    logic [CNT_W-1:0] cnt;

    assign accept = op_valid && !busy;
    assign commit = (accept && cycles == ONE_CYC) || (busy && cnt == '0);

    // Latency counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (accept && cycles > ONE_CYC) begin
            busy <= 1'b1;
            cnt  <= cycles - TWO_CYC;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - ONE_CYC;
        end
    end

    // A busy window always ends in a completion or keeps counting down.
    assert_busy_progress_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - ONE_CYC));
endmodule

// File: rtl/alu_slice.sv
// Top of the ALU slice: captures a request, runs it through the decoder and
// datapath, and registers the results at the end of the opcode latency.
// Assumes the caller keeps its own architectural registers from a_out etc.
module alu_slice
    import alu_slice_pkg::*;
#(
    parameter int W          = 8,
    parameter int MUL_CYCLES = 5,
    parameter int ORA_CYCLES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [7:0]   opcode,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] x_in,
    input  logic [7:0]   ccr_in,
    input  logic [W-1:0] mem_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] x_out,
    output logic [7:0]   ccr_out,
    output logic         done,
    output logic         illegal,
    output logic         busy
);
    localparam int MAX_CYC = (MUL_CYCLES > ORA_CYCLES) ? MUL_CYCLES : ORA_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [7:0]       lat_op, src_op;
    logic [W-1:0]     lat_a, lat_x, lat_m, src_a, src_x, src_m;
    logic [7:0]       lat_ccr, src_ccr;
    op_dec_t          dec;
    logic [CNT_W-1:0] cycles;
    logic             accept, commit;
    logic [W-1:0]     res_a, res_x;
    logic [7:0]       res_ccr;

    // Live inputs on the accept cycle, captured copies while busy.
    always_comb begin
        src_op  = busy ? lat_op  : opcode;
        src_a   = busy ? lat_a   : a_in;
        src_x   = busy ? lat_x   : x_in;
        src_ccr = busy ? lat_ccr : ccr_in;
        src_m   = busy ? lat_m   : mem_in;
    end

    // Capture the request operands on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_op  <= OPC_NOP;
            lat_a   <= '0;
            lat_x   <= '0;
            lat_ccr <= CCR_FIXED;
            lat_m   <= '0;
        end else if (accept) begin
            lat_op  <= opcode;
            lat_a   <= a_in;
            lat_x   <= x_in;
            lat_ccr <= ccr_in;
            lat_m   <= mem_in;
        end
    end

    alu_slice_decode #(
        .MUL_CYCLES(MUL_CYCLES), .ORA_CYCLES(ORA_CYCLES), .CNT_W(CNT_W)
    ) u_decode (
        .opcode(src_op), .dec(dec), .cycles(cycles)
    );

    alu_slice_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cycles(cycles),
        .accept(accept), .commit(commit), .busy(busy)
    );

    alu_slice_exec #(.W(W)) u_exec (
        .dec(dec), .a(src_a), .x(src_x), .ccr(src_ccr), .m(src_m),
        .res_a(res_a), .res_x(res_x), .res_ccr(res_ccr)
    );

    // Result registers and completion strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_out   <= '0;
            x_out   <= '0;
            ccr_out <= CCR_FIXED;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= commit;
            illegal <= commit && (dec.kind == K_BAD);
            if (commit) begin
                a_out   <= res_a;
                x_out   <= res_x;
                ccr_out <= res_ccr;
            end
        end
    end

    assert_ccr_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_out[6:5] == 2'b11);

    assert_illegal_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);

    assert_done_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_hold_while_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> ($stable(a_out) && $stable(x_out) && $stable(ccr_out) && !done));
endmodule

// File: tb/alu_slice_tb.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops and
// compares them on each done pulse.
module alu_slice_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] opcode = 8'h9D;
    logic [7:0] a_in = '0, x_in = '0, ccr_in = '0, mem_in = '0;
    logic [7:0] a_out, x_out, ccr_out;
    logic       done, illegal, busy;
    int         cyc = 0;
    int         n_tests = 0;
    int         n_fail = 0;
    bit         mon_on = 1'b0;

    typedef struct {
        logic [7:0] a;
        logic [7:0] x;
        logic [7:0] c;
        logic       ill;
        int         due;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    alu_slice u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .a_in(a_in), .x_in(x_in), .ccr_in(ccr_in), .mem_in(mem_in),
        .a_out(a_out), .x_out(x_out), .ccr_out(ccr_out),
        .done(done), .illegal(illegal), .busy(busy)
    );

    // Reference model written from the requirements.
    function automatic void model(input logic [7:0] op, a, x, c, m,
                                  output exp_t e, output int lat);
        logic [7:0] v;
        logic [15:0] p;
        e.a = a; e.x = x; e.c = c; e.ill = 1'b0; lat = 1;
        v = (op[4]) ? x : a;
        case (op)
            8'h48, 8'h58: begin
                v = {v[6:0], 1'b0};
                e.c[0] = op[4] ? x[7] : a[7];
                e.c[2] = v[7]; e.c[1] = (v == 8'h00); e.c[7] = v[7] ^ e.c[0];
                if (op[4]) e.x = v; else e.a = v;
            end
            8'h44, 8'h54: begin
                e.c[0] = v[0];
                v = {1'b0, v[7:1]};
                e.c[2] = 1'b0; e.c[1] = (v == 8'h00); e.c[7] = e.c[0];
                if (op[4]) e.x = v; else e.a = v;
            end
            8'h40, 8'h50: begin
                e.c[7] = (v == 8'h80);
                v = 8'h00 - v;
                e.c[2] = v[7]; e.c[1] = (v == 8'h00); e.c[0] = (v != 8'h00);
                if (op[4]) e.x = v; else e.a = v;
            end
            8'h62: e.a = {a[3:0], a[7:4]};
            8'h42: begin
                p = 16'(a) * 16'(x);
                e.x = p[15:8]; e.a = p[7:0];
                e.c[4] = 1'b0; e.c[0] = 1'b0; lat = 5;
            end
            8'hAA: begin
                e.a = a | m;
                e.c[7] = 1'b0; e.c[2] = e.a[7]; e.c[1] = (e.a == 8'h00); lat = 2;
            end
            8'h9D: ;
            default: e.ill = 1'b1;
        endcase
        e.c[6] = 1'b1; e.c[5] = 1'b1;
    endfunction

    // Driver: one request; flood keeps op_valid high with other data while busy.
    task automatic issue(input logic [7:0] op, a, x, c, m, input bit flood, input string tag);
        exp_t e;
        int   lat;
        @(negedge clk);
        model(op, a, x, c, m, e, lat);
        e.due = cyc + lat;
        e.tag = tag;
        sbq.push_back(e);
        op_valid = 1'b1; opcode = op; a_in = a; x_in = x; ccr_in = c; mem_in = m;
        @(posedge clk);
        if (lat > 1) begin
            @(negedge clk);
            if (flood) begin
                opcode = 8'h48; a_in = ~a; x_in = ~x; ccr_in = ~c; mem_in = 8'hFF;
            end else begin
                op_valid = 1'b0;
            end
            repeat (lat - 1) @(posedge clk);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        op_valid = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    // Monitor: compare every done against the scoreboard head.
    always @(negedge clk) begin
        if (mon_on) begin
            if (done) begin
                n_tests++;
                if (sbq.size() == 0) begin
                    n_fail++;
                    $display("FAIL R12 unexpected done: a=%h x=%h ccr=%h expected no completion",
                             a_out, x_out, ccr_out);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    if (a_out !== e.a || x_out !== e.x || ccr_out !== e.c ||
                        illegal !== e.ill || cyc != e.due) begin
                        n_fail++;
                        $display("FAIL %s: a=%h x=%h ccr=%h ill=%b cyc=%0d expected a=%h x=%h ccr=%h ill=%b cyc=%0d",
                                 e.tag, a_out, x_out, ccr_out, illegal, cyc,
                                 e.a, e.x, e.c, e.ill, e.due);
                    end
                end
            end
            if (sbq.size() > 0 && cyc > sbq[0].due) begin
                n_tests++;
                n_fail++;
                $display("FAIL %s R11 missing done: cyc=%0d expected done at %0d",
                         sbq[0].tag, cyc, sbq[0].due);
                void'(sbq.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected end of stimulus");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        n_tests++;
        if (a_out !== 8'h00 || x_out !== 8'h00 || ccr_out !== 8'h60 ||
            done !== 1'b0 || illegal !== 1'b0 || busy !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: a=%h x=%h ccr=%h done=%b ill=%b busy=%b expected 00 00 60 0 0 0",
                     a_out, x_out, ccr_out, done, illegal, busy);
        end
        mon_on = 1'b1;

        issue(8'h9D, 8'h12, 8'h34, 8'h00, 8'h00, 0, "R8 nop R10 fixed bits");
        idle(2);
        issue(8'h48, 8'h81, 8'h55, 8'h00, 8'h00, 0, "R2 lsla carry");
        issue(8'h48, 8'h80, 8'h55, 8'h18, 8'h00, 0, "R2 lsla zero");
        issue(8'h58, 8'hAA, 8'h40, 8'h00, 8'h00, 0, "R2 lslx negative");
        issue(8'h44, 8'h01, 8'h77, 8'h04, 8'h00, 0, "R3 lsra to zero");
        issue(8'h54, 8'h77, 8'hFE, 8'h9F, 8'h00, 0, "R3 lsrx");
        issue(8'h40, 8'h80, 8'h00, 8'h00, 8'h00, 0, "R4 nega 0x80");
        issue(8'h40, 8'h00, 8'h00, 8'h81, 8'h00, 0, "R4 nega zero");
        issue(8'h50, 8'h33, 8'h01, 8'h00, 8'h00, 0, "R4 negx one");
        issue(8'h62, 8'hA5, 8'h3C, 8'h9F, 8'h00, 0, "R5 nsa");
        idle(1);
        issue(8'h42, 8'hFF, 8'hFF, 8'hFF, 8'h00, 1, "R6 mul flood R12");
        issue(8'h42, 8'h10, 8'h10, 8'h11, 8'h00, 0, "R6 mul");
        issue(8'hAA, 8'h0F, 8'h22, 8'h81, 8'hF0, 1, "R7 ora flood R12");
        issue(8'hAA, 8'h00, 8'h22, 8'h95, 8'h00, 0, "R7 ora zero");
        issue(8'h00, 8'h5A, 8'hA5, 8'h9F, 8'h00, 0, "R9 undefined 0x00 R10");
        issue(8'hFF, 8'h01, 8'h02, 8'h08, 8'hFF, 0, "R9 undefined 0xFF");
        idle(1);
        issue(8'h42, 8'h03, 8'h07, 8'h00, 8'h00, 0, "R11 mul after idle");
        issue(8'h9D, 8'hC3, 8'h3C, 8'h10, 8'h00, 0, "R11 single after mul");
        issue(8'h54, 8'h00, 8'h01, 8'h00, 8'h00, 0, "R11 back to back");
        idle(10);

        n_tests++;
        if (sbq.size() != 0) begin
            n_fail++;
            $display("FAIL R11 pending results: %0d left expected 0", sbq.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule